// File: doc/BRIEF.md
# Accumulator ALU with Packed Flag Byte

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, a second operand and a 4-bit operation code. It returns the operation's result on a combinational path. The second operand may come from a register, from memory or from an immediate; the choice is made upstream. Decode writes the result back to the accumulator.

The block owns the four status flags: zero, subtract, half-carry and carry. They sit in a register that loads on a clock edge only while the load input is high. The stored carry is the carry-in for the add-with-carry and subtract-with-borrow operations. Outside logic sees the flags as one byte with the four flags in the upper nibble and zeros in the lower nibble.

The supported operations are:
- four arithmetic operations that produce a half-carry and a carry (or borrow) flag,
- three bitwise logic operations,
- accumulator inversion,
- two operations that force or toggle the carry flag.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears the flag byte to 0x00. The flag byte layout is Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3..0 always read 0.
- R2: Op 0 (add) gives result = (acc + operand) mod 256, with N=0. H=1 when the low nibbles produce a carry out of bit 3. C=1 when there is a carry out of bit 7.
- R3: Op 1 (add with carry) behaves like op 0, except that the stored C flag is added as a third term in both the result and the H/C computation.
- R4: Op 2 (subtract) gives result = (acc - operand) mod 256, with N=1. H=1 when the low nibble of the operand is greater than the low nibble of acc. C=1 when the operand is greater than acc (a borrow).
- R5: Op 3 (subtract with borrow) subtracts the operand and the stored C flag, with N=1. H=1 when low(operand)+C > low(acc). C=1 when operand+C > acc.
- R6: Ops 4, 5 and 6 give acc AND, OR and XOR operand, with N=0 and C=0. H=1 for AND and H=0 for OR and XOR.
- R7: For ops 0 to 6, Z=1 exactly when the 8-bit result is zero.
- R8: Op 7 gives result = bitwise inverse of acc. It sets N and H and leaves Z and C unchanged.
- R9: Op 8 forces C=1 and op 9 inverts C. Both clear N and H, keep Z, and present acc unchanged on the result.
- R10: While flag load is low, the flag byte holds its value whatever the operation. The result output still follows the inputs combinationally.
- R11: Op codes 10 to 15 present acc unchanged on the result and leave the flag byte unchanged even with flag load high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| acc_in | input | 8 | Accumulator value |
| operand_in | input | 8 | Second operand |
| flag_load | input | 1 | Load the new flags at the next rising edge |
| result_out | output | 8 | Combinational result of the selected operation |
| flag_byte | output | 8 | Registered flags Z,N,H,C in bits 7..4, zeros below |

## Verification
The arithmetic operations are tried at the nibble and byte wrap points: 0x0F+0x01 gives a half-carry with no full carry, 0xFF+0x01 gives both carries and a zero result, and 0x00-0x01 gives both borrows. Each of these is run with the carry-in at 0 and at 1, which tells the carry-using operations apart from the plain ones. Random operands against a behavioural model cover the remaining space for every op code. Directed steps check that the zero flag survives inversion and the carry operations, that the flag register holds while flag load is low, and that unused codes change nothing.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;
    localparam int FLAG_N = 4;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CPL = 4'd7,
        OP_SCF = 4'd8,
        OP_CCF = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_INV = 2'd3
    } logic_sel_e;

    function automatic logic [DATA_W-1:0] pack_flags(input flags_t f);
        return {f, {(DATA_W-FLAG_N){1'b0}}};
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         half
);
    localparam int H = W / 2;

    logic [W:0] full;
    logic [H:0] low;

    // Carry and borrow both appear as the bit just above the operand width.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        end
    end

    assign res   = full[W-1:0];
    assign carry = full[W];
    assign half  = low[H];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic [W-1:0]                a,
    input  logic [W-1:0]                b,
    input  acc_alu_pkg::logic_sel_e     sel,
    output logic [W-1:0]                res
);
    import acc_alu_pkg::*;

    always_comb begin
        case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  acc_alu_pkg::flags_t d,
    output acc_alu_pkg::flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   acc_in,
    input  logic [W-1:0]   operand_in,
    input  logic           flag_load,
    output logic [W-1:0]   result_out,
    output logic [W-1:0]   flag_byte
);
    flags_t     flags_q;
    flags_t     flags_d;
    logic       is_sub;
    logic       use_cin;
    logic [W-1:0] as_res;
    logic       as_carry;
    logic       as_half;
    logic [W-1:0] lg_res;
    logic_sel_e lg_sel;

    assign is_sub  = (op_code == OP_SUB) || (op_code == OP_SBC);
    assign use_cin = (op_code == OP_ADC) || (op_code == OP_SBC);

    acc_alu_addsub #(.W(W)) u_addsub (
        .a     (acc_in),
        .b     (operand_in),
        .cin   (use_cin & flags_q.c),
        .sub   (is_sub),
        .res   (as_res),
        .carry (as_carry),
        .half  (as_half)
    );

    always_comb begin
        case (op_code)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_INV;
        endcase
    end

    acc_alu_logic #(.W(W)) u_logic (
        .a   (acc_in),
        .b   (operand_in),
        .sel (lg_sel),
        .res (lg_res)
    );

    always_comb begin
        result_out = acc_in;
        flags_d    = flags_q;
        case (op_code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result_out = as_res;
                flags_d.z  = (as_res == '0);
                flags_d.n  = is_sub;
                flags_d.h  = as_half;
                flags_d.c  = as_carry;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_out = lg_res;
                flags_d.z  = (lg_res == '0);
                flags_d.n  = 1'b0;
                flags_d.h  = (op_code == OP_AND);
                flags_d.c  = 1'b0;
            end
            OP_CPL: begin
                result_out = lg_res;
                flags_d.n  = 1'b1;
                flags_d.h  = 1'b1;
            end
            OP_SCF: begin
                flags_d.n = 1'b0;
                flags_d.h = 1'b0;
                flags_d.c = 1'b1;
            end
            OP_CCF: begin
                flags_d.n = 1'b0;
                flags_d.h = 1'b0;
                flags_d.c = ~flags_q.c;
            end
            default: ;
        endcase
    end

    acc_alu_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (flag_load),
        .d    (flags_d),
        .q    (flags_q)
    );

    assign flag_byte = pack_flags(flags_q);

    // R1
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flag_byte[3:0] == 4'd0);

    // R9
    scf_sets_c_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_load && op_code == OP_SCF) |=> flag_byte[4]);

    // R9
    ccf_flips_c_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_load && op_code == OP_CCF) |=> flag_byte[4] != $past(flag_byte[4]));

    // R7
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_load && op_code <= OP_XOR) |=> flag_byte[7] == ($past(result_out) == '0));

    // R4
    sub_sets_n_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_load && (op_code == OP_SUB || op_code == OP_SBC)) |=> flag_byte[6]);

    // R6
    and_h_set_c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_load && op_code == OP_AND) |=> (flag_byte[5] && !flag_byte[4]));

    // R11
    unused_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code > OP_CCF) |=> $stable(flag_byte));

endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_code;
    logic [7:0] acc_in;
    logic [7:0] operand_in;
    logic       flag_load;
    logic [7:0] result_out;
    logic [7:0] flag_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .clk        (clk),
        .rst        (rst),
        .op_code    (op_code),
        .acc_in     (acc_in),
        .operand_in (operand_in),
        .flag_load  (flag_load),
        .result_out (result_out),
        .flag_byte  (flag_byte)
    );

    // {op[3:0], acc[7:0], operand[7:0], carry_in}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {4'd0, 8'h0F, 8'h01, 1'b0},
        {4'd0, 8'hFF, 8'h01, 1'b0},
        {4'd0, 8'h00, 8'h00, 1'b1},
        {4'd0, 8'h80, 8'h80, 1'b0},
        {4'd1, 8'hFF, 8'h00, 1'b1},
        {4'd1, 8'h0F, 8'h00, 1'b1},
        {4'd1, 8'h0F, 8'h01, 1'b0},
        {4'd2, 8'h00, 8'h01, 1'b0},
        {4'd2, 8'h10, 8'h01, 1'b1},
        {4'd2, 8'h42, 8'h42, 1'b0},
        {4'd3, 8'h10, 8'h0F, 1'b1},
        {4'd3, 8'h00, 8'hFF, 1'b1},
        {4'd3, 8'h05, 8'h05, 1'b1},
        {4'd4, 8'hF0, 8'h0F, 1'b1},
        {4'd4, 8'hFF, 8'h3C, 1'b0},
        {4'd5, 8'h00, 8'h00, 1'b1},
        {4'd6, 8'hA5, 8'hA5, 1'b1},
        {4'd6, 8'hA5, 8'h5A, 1'b0}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        logic [7:0] r;
        logic z, n, h, c;
        int ai, bi, ci, s;
        ai = int'(a); bi = int'(b);
        z = f[7]; n = f[6]; h = f[5]; c = f[4];
        ci = (op == 4'd1 || op == 4'd3) ? int'(f[4]) : 0;
        r = a;
        case (op)
            4'd0, 4'd1: begin
                s = ai + bi + ci; r = s[7:0];
                n = 0; h = ((ai % 16) + (bi % 16) + ci) > 15; c = s > 255; z = (r == 0);
            end
            4'd2, 4'd3: begin
                s = ai - bi - ci; r = s[7:0];
                n = 1; h = (ai % 16) < ((bi % 16) + ci); c = ai < (bi + ci); z = (r == 0);
            end
            4'd4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
            4'd5: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
            4'd6: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
            4'd7: begin r = ~a; n = 1; h = 1; end
            4'd8: begin n = 0; h = 0; c = 1; end
            4'd9: begin n = 0; h = 0; c = !c; end
            default: ;
        endcase
        return {r, z, n, h, c, 4'b0000};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic ld, input string req);
        logic [15:0] e;
        @(negedge clk);
        op_code = op; acc_in = a; operand_in = b; flag_load = ld;
        e = model(op, a, b, shadow);
        #1 chk(req, "result", result_out, e[15:8]);
        @(negedge clk);
        chk(req, "flags", flag_byte, ld ? e[7:0] : shadow);
        if (ld) shadow = e[7:0];
        flag_load = 1'b0;
    endtask

    task automatic set_carry(input logic cv);
        step(4'd8, 8'h00, 8'h00, 1'b1, "R9");
        if (!cv) step(4'd9, 8'h00, 8'h00, 1'b1, "R9");
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_code = 4'd0; acc_in = 8'h00; operand_in = 8'h00; flag_load = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset clears flags even with load requested
        chk("R1", "reset flags", flag_byte, 8'h00);
        rst = 1'b0; flag_load = 1'b0;
        shadow = 8'h00;

        for (int i = 0; i < NV; i++) begin
            set_carry(VEC[i][0]);
            step(VEC[i][20:17], VEC[i][16:9], VEC[i][8:1], 1'b1, req_of(VEC[i][20:17]));
        end

        for (int i = 0; i < 150; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 9));
            step(op, 8'($urandom), 8'($urandom), 1'b1, req_of(op));
        end

        // R7 and R8: Z=1 from a zero add result survives inversion
        step(4'd0, 8'hFF, 8'h01, 1'b1, "R7");
        step(4'd7, 8'h3C, 8'h00, 1'b1, "R8");
        chk("R8", "Z kept", {7'd0, flag_byte[7]}, 8'd1);
        // R9: carry ops keep Z and pass acc through
        step(4'd8, 8'h77, 8'h11, 1'b1, "R9");
        step(4'd9, 8'h77, 8'h11, 1'b1, "R9");
        chk("R9", "Z kept after CCF", {7'd0, flag_byte[7]}, 8'd1);

        // R10: no load keeps flags, result still live
        step(4'd2, 8'h00, 8'h01, 1'b0, "R10");
        step(4'd4, 8'hF0, 8'h0F, 1'b0, "R10");

        // R11: unused codes with load high
        for (int k = 10; k < 16; k++) step(4'(k), 8'h5A, 8'hFF, 1'b1, "R11");

        // R1: reset after activity
        set_carry(1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "reset after use", flag_byte, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule